// File: doc/BRIEF.md
# Error-Flagging SRAM Control Front End

This block is a clocked behavioural model of the control front end of a 32-bit word memory that carries an error-detection flag. It takes two chip enables (one active-low, one active-high), an active-low write strobe and an active-low output enable. From these it derives one of five operating modes, whether the model drives the data bus, and whether the model drives the error-flag pin and at what level. The bus is split into an input word, an output word and a drive-enable, so that a wrapper can add the tri-state pad.

All control, address and data inputs pass through one register stage before use. A small word array stands in for the storage. The low address bits select a word. A sticky error flag is armed through a test input and set by the next read. The flag then survives every operation except a read that begins with the output enable falling while the device is already selected. Read operations entered through a chip enable leave the flag set.

Top module: `edac_sram_front`

## Requirements
- R1: With `chipSelN` high, `mode` is 0 (standby, no scrub), and `dataOe` and `mbeOe` are both low, whatever the other controls are.
- R2: With `chipSelN` low and `chipSel` low, `mode` is 1 (standby with scrub) and `dataOe` is low.
- R3: With both enables active, `writeN` high and `outEnN` low, `mode` is 2 (read), `dataOe` is high and `dataOut` is the stored word selected by `addr[IDX_W-1:0]`.
- R4: With both enables active and `writeN` low, `mode` is 3 (write) and `dataOe` is low, whatever `outEnN` is.
- R5: With both enables active and both `writeN` and `outEnN` high, `mode` is 4 (selected, bus idle) and `dataOe` is low.
- R6: A write stores the address and data present in its last write-mode cycle. The word is committed when write mode ends, whether `writeN` rises or a chip enable deasserts first. Only `addr[IDX_W-1:0]` selects the word, so addresses differing in upper bits alias.
- R7: `mbeOe` is high exactly when `chipSelN` and `outEnN` are both low. This includes scrub standby. While `mbeOe` is low, `mbeValue` is 0; while it is high, `mbeValue` shows the error flag.
- R8: A pulse on `errInject` arms an error. The first read cycle after arming sets the error flag.
- R9: Once set, the flag stays set through further reads, standby, scrub and reads entered by a chip enable.
- R10: A read entered from mode 4 by `outEnN` falling clears the flag, unless an armed error is pending. Later reads show `mbeValue` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| chipSelN | input | 1 | Active-low chip enable |
| chipSel | input | 1 | Active-high chip enable |
| writeN | input | 1 | Active-low write strobe |
| outEnN | input | 1 | Active-low output enable |
| addr | input | 19 | Word address |
| dataIn | input | 32 | Write data from the bus |
| errInject | input | 1 | Test input arming an error for the next read |
| mode | output | 3 | Operating mode code (0..4) |
| dataOut | output | 32 | Read data to the bus |
| dataOe | output | 1 | Data bus drive enable |
| mbeValue | output | 1 | Level driven on the error-flag pin |
| mbeOe | output | 1 | Error-flag pin drive enable |

## Verification
Mode, `dataOe`, `mbeOe` and read data are due one clock after the controls change, because of the single input register. The bench drives on the falling edge and samples on the next falling edge. The error flag moves one clock later than the read mode that causes it. The bench therefore checks `mbeValue` both one and two cycles after `outEnN` falls, showing the old value first and then the new one. A write becomes readable two clocks after write mode ends, and the bench leaves a wider margin before reading back.

// File: rtl/edac_front_pkg.sv
package edac_front_pkg;

  typedef enum logic [2:0] {
    MODE_IDLE_NOSCRUB = 3'd0,
    MODE_IDLE_SCRUB   = 3'd1,
    MODE_READ         = 3'd2,
    MODE_WRITE        = 3'd3,
    MODE_SEL_HOLD     = 3'd4
  } devMode_t;

  typedef struct packed {
    logic readEn;
    logic writeEn;
    logic commit;
  } dpStrobe_t;

  function automatic devMode_t decodeMode(input logic csN, input logic cs,
                                          input logic weN, input logic oeN);
    if (csN)       return MODE_IDLE_NOSCRUB;
    else if (!cs)  return MODE_IDLE_SCRUB;
    else if (!weN) return MODE_WRITE;
    else if (!oeN) return MODE_READ;
    else           return MODE_SEL_HOLD;
  endfunction

endpackage

// File: rtl/edac_front_ctrl.sv
module edac_front_ctrl
  import edac_front_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      chipSelN,
  input  logic      chipSel,
  input  logic      writeN,
  input  logic      outEnN,
  input  logic      errInject,
  output devMode_t  modeNow,
  output dpStrobe_t strobe,
  output logic      mbeValue,
  output logic      mbeOe
);

  logic     csNQ, csQ, weNQ, oeNQ, injQ;
  devMode_t prevMode;
  logic     writeLast;
  logic     injArm;
  logic     errFlag;
  logic     readEn, writeEn, oeRead;

  assign modeNow = decodeMode(csNQ, csQ, weNQ, oeNQ);
  assign readEn  = (modeNow == MODE_READ);
  assign writeEn = (modeNow == MODE_WRITE);
  // a read counts as output-enable controlled only when entered from the selected hold state
  assign oeRead  = readEn && (prevMode == MODE_SEL_HOLD);

  assign strobe.readEn  = readEn;
  assign strobe.writeEn = writeEn;
  assign strobe.commit  = writeLast && !writeEn;

  assign mbeOe    = !csNQ && !oeNQ;
  assign mbeValue = mbeOe && errFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csNQ      <= 1'b1;
      csQ       <= 1'b0;
      weNQ      <= 1'b1;
      oeNQ      <= 1'b1;
      injQ      <= 1'b0;
      prevMode  <= MODE_IDLE_NOSCRUB;
      writeLast <= 1'b0;
      injArm    <= 1'b0;
      errFlag   <= 1'b0;
    end else begin
      csNQ      <= chipSelN;
      csQ       <= chipSel;
      weNQ      <= writeN;
      oeNQ      <= outEnN;
      injQ      <= errInject;
      prevMode  <= modeNow;
      writeLast <= writeEn;
      injArm    <= (injArm && !readEn) || injQ;
      if (readEn && injArm)
        errFlag <= 1'b1;
      else if (oeRead)
        errFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/edac_front_data.sv
module edac_front_data
  import edac_front_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  dpStrobe_t         strobe,
  output logic [DATA_W-1:0] dataOut
);

  localparam int DEPTH = 1 << IDX_W;

  logic [IDX_W-1:0]  idxQ;
  logic [DATA_W-1:0] dataQ;
  logic [IDX_W-1:0]  pendIdx;
  logic [DATA_W-1:0] pendData;
  logic [DATA_W-1:0] wordBus [DEPTH];
  logic              unusedAddrBits;

  assign unusedAddrBits = ^addr[ADDR_W-1:IDX_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ     <= '0;
      dataQ    <= '0;
      pendIdx  <= '0;
      pendData <= '0;
    end else begin
      idxQ  <= addr[IDX_W-1:0];
      dataQ <= dataIn;
      if (strobe.writeEn) begin
        pendIdx  <= idxQ;
        pendData <= dataQ;
      end
    end
  end

  for (genvar w = 0; w < DEPTH; w++) begin : gWord
    logic [DATA_W-1:0] word;
    always_ff @(posedge clk) begin
      if (!rstN)
        word <= '0;
      else if (strobe.commit && (pendIdx == IDX_W'(w)))
        word <= pendData;
    end
    assign wordBus[w] = word;
  end

  assign dataOut = strobe.readEn ? wordBus[idxQ] : '0;

endmodule

// File: rtl/edac_sram_front.sv
module edac_sram_front
  import edac_front_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipSelN,
  input  logic              chipSel,
  input  logic              writeN,
  input  logic              outEnN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              errInject,
  output logic [2:0]        mode,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              mbeValue,
  output logic              mbeOe
);

  devMode_t  modeNow;
  dpStrobe_t strobe;

  edac_front_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .chipSelN (chipSelN),
    .chipSel  (chipSel),
    .writeN   (writeN),
    .outEnN   (outEnN),
    .errInject(errInject),
    .modeNow  (modeNow),
    .strobe   (strobe),
    .mbeValue (mbeValue),
    .mbeOe    (mbeOe)
  );

  edac_front_data #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .IDX_W (IDX_W)
  ) u_data (
    .clk    (clk),
    .rstN   (rstN),
    .addr   (addr),
    .dataIn (dataIn),
    .strobe (strobe),
    .dataOut(dataOut)
  );

  assign mode   = modeNow;
  assign dataOe = strobe.readEn;

endmodule

// File: rtl/edac_sram_front_chk.sv
module edac_sram_front_chk (
  input logic       clk,
  input logic       rstN,
  input logic       chipSelN,
  input logic       chipSel,
  input logic       writeN,
  input logic       outEnN,
  input logic [2:0] mode,
  input logic       dataOe,
  input logic       mbeValue,
  input logic       mbeOe
);

  assert_standby_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(chipSelN) |-> (!dataOe && !mbeOe && mode == 3'd0));

  assert_read_drives_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(!chipSelN && chipSel && writeN && !outEnN) |-> (dataOe && mode == 3'd2));

  assert_write_listens_R4: assert property (@(posedge clk) disable iff (!rstN)
    $past(!chipSelN && chipSel && !writeN) |-> (!dataOe && mode == 3'd3));

  assert_flag_enable_R7: assert property (@(posedge clk) disable iff (!rstN)
    mbeOe == $past(!chipSelN && !outEnN));

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(mbeValue) && $past(mbeOe) && mbeOe && $past(mode) != 3'd2) |-> mbeValue);

endmodule

bind edac_sram_front edac_sram_front_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .chipSelN (chipSelN),
  .chipSel  (chipSel),
  .writeN   (writeN),
  .outEnN   (outEnN),
  .mode     (mode),
  .dataOe   (dataOe),
  .mbeValue (mbeValue),
  .mbeOe    (mbeOe)
);

// File: tb/edac_sram_front_bench.sv
`timescale 1ns/1ps
module edac_sram_front_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        chipSelN, chipSel, writeN, outEnN, errInject;
  logic [18:0] addr;
  logic [31:0] dataIn;
  logic [2:0]  mode;
  logic [31:0] dataOut;
  logic        dataOe, mbeValue, mbeOe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [31:0] expMem [16];

  always #4 clk = ~clk;

  edac_sram_front u_edac_sram_front (
    .clk(clk), .rstN(rstN), .chipSelN(chipSelN), .chipSel(chipSel),
    .writeN(writeN), .outEnN(outEnN), .addr(addr), .dataIn(dataIn),
    .errInject(errInject), .mode(mode), .dataOut(dataOut), .dataOe(dataOe),
    .mbeValue(mbeValue), .mbeOe(mbeOe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctl(input logic csN, input logic cs, input logic weN, input logic oeN);
    chipSelN = csN; chipSel = cs; writeN = weN; outEnN = oeN;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] expMode(input logic csN, input logic cs,
                                         input logic weN, input logic oeN);
    if (csN) return 3'd0;
    if (!cs) return 3'd1;
    if (!weN) return 3'd3;
    if (!oeN) return 3'd2;
    return 3'd4;
  endfunction

  function automatic string modeTag(input logic [2:0] m);
    case (m)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic logic [31:0] wordFor(input int i);
    return 32'hA5000000 ^ (32'(i + 1) * 32'h01030507);
  endfunction

  task automatic doWrite(input logic [18:0] a, input logic [31:0] d, input bit endByEnable);
    addr = a; dataIn = d;
    ctl(1'b0, 1'b1, 1'b1, 1'b1);
    tick(1);
    writeN = 1'b0;
    tick(2);
    check("R4 bus input during write", {31'd0, dataOe}, 32'd0);
    if (endByEnable) begin
      chipSel = 1'b0;
      tick(1);
      writeN = 1'b1;
    end else begin
      writeN = 1'b1;
    end
    dataIn = ~d;
    tick(1);
    ctl(1'b0, 1'b1, 1'b1, 1'b1);
    tick(3);
    expMem[a[3:0]] = d;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [18:0] wrAddr [6];
    rstN = 1'b0; errInject = 1'b0; addr = '0; dataIn = '0;
    ctl(1'b1, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 16; i++) expMem[i] = 32'd0;
    tick(3);
    rstN = 1'b1;
    tick(1);
    check("R1 reset mode", {29'd0, mode}, 32'd0);
    check("R1 reset dataOe", {31'd0, dataOe}, 32'd0);
    check("R7 reset mbeOe", {31'd0, mbeOe}, 32'd0);

    // full sweep of the control decode
    for (int c = 0; c < 16; c++) begin
      logic [2:0] em;
      ctl(c[3], c[2], c[1], c[0]);
      addr = 19'h0; dataIn = 32'h0;
      tick(1);
      em = expMode(c[3], c[2], c[1], c[0]);
      check({modeTag(em), " mode"}, {29'd0, mode}, {29'd0, em});
      check({modeTag(em), " dataOe"}, {31'd0, dataOe}, {31'd0, em == 3'd2});
      check("R7 mbeOe decode", {31'd0, mbeOe}, {31'd0, !c[3] && !c[0]});
      check("R7 mbeValue clear flag", {31'd0, mbeValue}, 32'd0);
    end
    ctl(1'b1, 1'b0, 1'b1, 1'b1);
    tick(3);

    // writes ended alternately by the strobe and by an enable
    wrAddr[0] = 19'h00000; wrAddr[1] = 19'h00005; wrAddr[2] = 19'h0000F;
    wrAddr[3] = 19'h00003; wrAddr[4] = 19'h7FFF3; wrAddr[5] = 19'h12349;
    for (int i = 0; i < 6; i++) doWrite(wrAddr[i], wordFor(i), (i % 2) == 1);

    for (int i = 0; i < 16; i++) begin
      addr = 19'(i) | 19'h40000;
      ctl(1'b0, 1'b1, 1'b1, 1'b1);
      tick(1);
      outEnN = 1'b0;
      tick(1);
      check("R3 read dataOe", {31'd0, dataOe}, 32'd1);
      check("R6 read back word", dataOut, expMem[i]);
      outEnN = 1'b1;
      tick(1);
    end

    // error flag: arm, set, hold, clear
    ctl(1'b0, 1'b1, 1'b1, 1'b1);
    addr = 19'h5;
    errInject = 1'b1;
    tick(1);
    errInject = 1'b0;
    tick(2);
    outEnN = 1'b0;
    tick(1);
    check("R8 flag not yet set", {31'd0, mbeValue}, 32'd0);
    tick(1);
    check("R8 flag set by read", {31'd0, mbeValue}, 32'd1);
    tick(3);
    check("R9 flag held over reads", {31'd0, mbeValue}, 32'd1);
    chipSel = 1'b0;
    tick(1);
    check("R2 scrub mode", {29'd0, mode}, 32'd1);
    check("R7 scrub reports flag", {30'd0, mbeOe, mbeValue}, 32'd3);
    outEnN = 1'b1;
    tick(1);
    check("R7 scrub tristate flag", {30'd0, mbeOe, mbeValue}, 32'd0);
    outEnN = 1'b0;
    tick(1);
    chipSel = 1'b1;
    tick(3);
    check("R9 enable-entered read keeps flag", {30'd0, mbeOe, mbeValue}, 32'd3);
    chipSel = 1'b0;
    tick(1);
    outEnN = 1'b1;
    tick(1);
    chipSel = 1'b1;
    tick(1);
    check("R5 selected hold", {29'd0, mode}, 32'd4);
    outEnN = 1'b0;
    tick(1);
    check("R10 flag before clear", {30'd0, mbeOe, mbeValue}, 32'd3);
    tick(1);
    check("R10 flag cleared", {30'd0, mbeOe, mbeValue}, 32'd2);
    tick(3);
    check("R10 later reads low", {30'd0, mbeOe, mbeValue}, 32'd2);
    chipSelN = 1'b1;
    tick(1);
    check("R1 standby tristate flag", {30'd0, mbeOe, dataOe}, 32'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule